// File: doc/BRIEF.md
# Pad Function Multiplexer with Complement-Key Write Guard

This block is a register-mapped controller that decides, pad by pad, whether each pad is driven by a general-purpose I/O port or by one of sixteen alternate peripheral functions. It also holds a drive-strength code and a pull-resistor setting for every pad. Software reaches it through a simple synchronous register bus with address, write data, a write strobe, a read strobe and registered read data. The resulting per-pad controls go straight to the pad ring.

Three register groups are guarded: the peripheral-select words, the function-code words and the drive-strength words. A write to one of them is only taken when the bus write directly before it went to the key register and carried the bitwise complement of the new data. A guarded write that arrives without a matching key is dropped and raises a sticky error flag. The pull-resistor registers and the status register accept plain writes. The default build serves two banks of 32 pads each.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset all select, function, drive and pull state is 0, the error flag is clear, the key register reads 0, no key is armed and every pad output is 0.
- R2: The select word for bank b is at 0x100 + 4*b. Pad n is controlled by bit n%32 of word n/32, and `pad_periph[n]` follows that bit: 1 routes the pad to its peripheral and 0 keeps it on GPIO.
- R3: The function words start at 0x200, with eight 4-bit fields per word. Pad n uses word n/8, bits 4*(n%8) to 4*(n%8)+3, and `pad_func[4n+3:4n]` follows that field.
- R4: The drive words start at 0x300, with one 4-bit slot per pad laid out like R3. Even pads have a 2-bit code (6 mA steps) and odd pads have a 3-bit code (3 mA steps). The code is mA/step - 1, so all-ones means 24 mA. Bits outside the code width are not stored and read as 0. `pad_drive[3n+2:3n]` gives the code zero-extended.
- R5: A write to a select, function or drive word is stored only when the bus write directly before it went to the key register at 0x000 with the bitwise complement of its data. Reads in between do not break this pairing.
- R6: Any bus write disarms the key, whether or not that write is accepted, and whatever address it targets. One key write therefore admits at most one guarded write.
- R7: A guarded write that is not admitted leaves its register unchanged and sets bit 0 of the status word at 0x004. That bit is sticky. Writing a 1 to it clears it, and writing a 0 leaves it set.
- R8: The pull-enable words at 0x400 + 4*b and the pull-direction words at 0x500 + 4*b accept plain writes. `pad_pull_up` equals enable AND direction, and `pad_pull_dn` equals enable AND NOT direction. With the enable bit at 0, the direction bit has no effect.
- R9: Every register, including the key register, reads back its stored value on `bus_rdata` in the cycle after `bus_rd`. Unmapped or misaligned addresses read 0 and ignore writes.
- R10: A write to the key register replaces any earlier key, so only the most recent key is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| pad_periph | output | NPAD | 1 = pad routed to peripheral |
| pad_func | output | 4*NPAD | Alternate function code per pad |
| pad_drive | output | 3*NPAD | Drive-strength code per pad |
| pad_pull_up | output | NPAD | Pull-up active |
| pad_pull_dn | output | NPAD | Pull-down active |

## Verification
A key tracker that is wrongly left armed lets a second guarded write through, and that write changes a pad output in the very next cycle. A tracker that is wrongly left disarmed drops a paired write, which shows at once as a pad output that fails to change and as a status error flag that sets. A wrong drive mask or a wrong field offset shows up as a stray bit in `pad_drive` or in the read-back word one cycle after the write. Because the reference model is compared against every pad output on every clock, a state divergence is reported in the cycle it first reaches a pin.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int PADS_BANK = 32;
  localparam int NB_DEF    = 2;
  localparam int FLD_W     = 4;
  localparam int FLD_WORD  = DW / FLD_W;
  localparam int DRV_W     = 3;

  localparam logic [3:0] RG_CTRL = 4'h0;
  localparam logic [3:0] RG_SEL  = 4'h1;
  localparam logic [3:0] RG_FUNC = 4'h2;
  localparam logic [3:0] RG_DRV  = 4'h3;
  localparam logic [3:0] RG_PEN  = 4'h4;
  localparam logic [3:0] RG_PDIR = 4'h5;

  // code width of one pad's drive field: odd pads are finer grained
  function automatic int drv_width(input int pad);
    return (pad % 2 == 1) ? 3 : 2;
  endfunction

  function automatic logic [DW-1:0] drv_word_mask(input int word);
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < FLD_WORD; s++)
      for (int b = 0; b < drv_width(word * FLD_WORD + s); b++)
        m[s * FLD_W + b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmx_unlock.sv
module pmx_unlock #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          key_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] key_q,
  output logic          key_ok
);
  logic          armed_q, armed_d;
  logic [DW-1:0] key_d;

  always_comb begin
    armed_d = armed_q;
    key_d   = key_q;
    if (wr_en) begin
      armed_d = key_sel;
      if (key_sel) key_d = wdata;
    end
  end

  assign key_ok = armed_q && (key_q == ~wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      key_q   <= '0;
    end else begin
      armed_q <= armed_d;
      key_q   <= key_d;
    end
  end
endmodule

// File: rtl/pmx_wordbank.sv
module pmx_wordbank #(
  parameter int DW           = 32,
  parameter int N            = 2,
  parameter bit DRIVE_LAYOUT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [5:0]      idx,
  input  logic [DW-1:0]   wdata,
  output logic [N*DW-1:0] words
);
  for (genvar i = 0; i < N; i++) begin : g_word
    localparam logic [DW-1:0] MASK =
      DRIVE_LAYOUT ? pmx_pkg::drv_word_mask(i) : {DW{1'b1}};
    logic [DW-1:0] q, d;
    logic          en;

    assign en = we && (idx == 6'(i));

    always_comb begin
      d = q;
      if (en) d = wdata & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign words[i*DW +: DW] = q;
  end
endmodule

// File: rtl/pmx_pad_map.sv
module pmx_pad_map #(
  parameter int NPAD = 64
) (
  input  logic [NPAD-1:0]   sel_w,
  input  logic [NPAD*4-1:0] func_w,
  input  logic [NPAD*4-1:0] drv_w,
  input  logic [NPAD-1:0]   pen_w,
  input  logic [NPAD-1:0]   pdir_w,
  output logic [NPAD-1:0]   pad_periph,
  output logic [NPAD*4-1:0] pad_func,
  output logic [NPAD*3-1:0] pad_drive,
  output logic [NPAD-1:0]   pad_pull_up,
  output logic [NPAD-1:0]   pad_pull_dn
);
  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    assign pad_periph[p]      = sel_w[p];
    assign pad_func[p*4 +: 4] = func_w[p*4 +: 4];
    assign pad_drive[p*3 +: 3] = drv_w[p*4 +: 3];
    assign pad_pull_up[p]     = pen_w[p] & pdir_w[p];
    assign pad_pull_dn[p]     = pen_w[p] & ~pdir_w[p];
  end
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl #(
  parameter int NB = pmx_pkg::NB_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [pmx_pkg::AW-1:0]        bus_addr,
  input  logic [pmx_pkg::DW-1:0]        bus_wdata,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  output logic [pmx_pkg::DW-1:0]        bus_rdata,
  output logic [NB*pmx_pkg::PADS_BANK-1:0]   pad_periph,
  output logic [NB*pmx_pkg::PADS_BANK*4-1:0] pad_func,
  output logic [NB*pmx_pkg::PADS_BANK*3-1:0] pad_drive,
  output logic [NB*pmx_pkg::PADS_BANK-1:0]   pad_pull_up,
  output logic [NB*pmx_pkg::PADS_BANK-1:0]   pad_pull_dn
);
  import pmx_pkg::*;
  localparam int NPAD = NB * PADS_BANK;
  localparam int FW   = NPAD / FLD_WORD;

  logic [3:0] region;
  logic [5:0] idx;
  logic       aligned;
  logic       hit_key, hit_stat, hit_sel, hit_func, hit_drv, hit_pen, hit_pdir;
  logic       guarded_hit, key_ok, reject;
  logic [DW-1:0] key_q;
  logic          err_q, err_d;
  logic [DW-1:0] rd_val, rdata_q, rdata_d;

  logic [NB*DW-1:0] sel_w, pen_w, pdir_w;
  logic [FW*DW-1:0] func_w, drv_w;

  assign region  = bus_addr[11:8];
  assign idx     = bus_addr[7:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  assign hit_key  = aligned && region == RG_CTRL && idx == 6'd0;
  assign hit_stat = aligned && region == RG_CTRL && idx == 6'd1;
  assign hit_sel  = aligned && region == RG_SEL  && idx < 6'(NB);
  assign hit_func = aligned && region == RG_FUNC && idx < 6'(FW);
  assign hit_drv  = aligned && region == RG_DRV  && idx < 6'(FW);
  assign hit_pen  = aligned && region == RG_PEN  && idx < 6'(NB);
  assign hit_pdir = aligned && region == RG_PDIR && idx < 6'(NB);

  assign guarded_hit = hit_sel | hit_func | hit_drv;
  assign reject      = bus_wr & guarded_hit & ~key_ok;

  pmx_unlock #(.DW(DW)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .key_sel(hit_key),
    .wdata(bus_wdata), .key_q(key_q), .key_ok(key_ok)
  );

  pmx_wordbank #(.DW(DW), .N(NB), .DRIVE_LAYOUT(1'b0)) u_sel (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_sel & key_ok),
    .idx(idx), .wdata(bus_wdata), .words(sel_w)
  );
  pmx_wordbank #(.DW(DW), .N(FW), .DRIVE_LAYOUT(1'b0)) u_func (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_func & key_ok),
    .idx(idx), .wdata(bus_wdata), .words(func_w)
  );
  pmx_wordbank #(.DW(DW), .N(FW), .DRIVE_LAYOUT(1'b1)) u_drv (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_drv & key_ok),
    .idx(idx), .wdata(bus_wdata), .words(drv_w)
  );
  pmx_wordbank #(.DW(DW), .N(NB), .DRIVE_LAYOUT(1'b0)) u_pen (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_pen),
    .idx(idx), .wdata(bus_wdata), .words(pen_w)
  );
  pmx_wordbank #(.DW(DW), .N(NB), .DRIVE_LAYOUT(1'b0)) u_pdir (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_pdir),
    .idx(idx), .wdata(bus_wdata), .words(pdir_w)
  );

  pmx_pad_map #(.NPAD(NPAD)) u_map (
    .sel_w(sel_w), .func_w(func_w), .drv_w(drv_w), .pen_w(pen_w),
    .pdir_w(pdir_w), .pad_periph(pad_periph), .pad_func(pad_func),
    .pad_drive(pad_drive), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
  );

  // sticky error flag, write-one-to-clear
  always_comb begin
    err_d = err_q;
    if (reject)                                   err_d = 1'b1;
    else if (bus_wr && hit_stat && bus_wdata[0])  err_d = 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (hit_key)  rd_val = key_q;
    if (hit_stat) rd_val = {{(DW-1){1'b0}}, err_q};
    for (int i = 0; i < NB; i++) begin
      if (hit_sel  && idx == 6'(i)) rd_val = sel_w[i*DW +: DW];
      if (hit_pen  && idx == 6'(i)) rd_val = pen_w[i*DW +: DW];
      if (hit_pdir && idx == 6'(i)) rd_val = pdir_w[i*DW +: DW];
    end
    for (int i = 0; i < FW; i++) begin
      if (hit_func && idx == 6'(i)) rd_val = func_w[i*DW +: DW];
      if (hit_drv  && idx == 6'(i)) rd_val = drv_w[i*DW +: DW];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pmx_chk.sv
module pmx_chk #(
  parameter int NB = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] periph0,
  input logic [31:0] pull_up0,
  input logic [31:0] pull_dn0,
  input logic        err
);
  logic        armed_s;
  logic [31:0] key_s;
  logic        valid, guarded, sel0, pen0, stat;
  logic [31:0] pull_any;

  // independent shadow of the key pairing rule
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_s <= 1'b0;
      key_s   <= '0;
    end else if (bus_wr) begin
      armed_s <= (bus_addr == 12'h000);
      if (bus_addr == 12'h000) key_s <= bus_wdata;
    end
  end

  assign valid    = armed_s && ((key_s ^ bus_wdata) == 32'hFFFF_FFFF);
  assign sel0     = (bus_addr == 12'h100);
  assign pen0     = (bus_addr == 12'h400);
  assign stat     = (bus_addr == 12'h004);
  assign guarded  = (bus_addr[1:0] == 2'b00) &&
                    ((bus_addr[11:8] == 4'h1 && bus_addr[7:2] < 6'(NB)) ||
                     (bus_addr[11:8] == 4'h2 && bus_addr[7:2] < 6'(NB*4)) ||
                     (bus_addr[11:8] == 4'h3 && bus_addr[7:2] < 6'(NB*4)));
  assign pull_any = pull_up0 | pull_dn0;

  assert_sel_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel0 && !valid) |=> $stable(periph0));

  assert_sel_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel0 && valid) |=> (periph0 == $past(bus_wdata)));

  assert_reject_sets_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && guarded && !valid) |=> err);

  assert_err_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && stat && bus_wdata[0]) |=> !err);

  assert_pull_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && pen0) |=> (pull_any == $past(bus_wdata)));
endmodule

bind pinmux_ctrl pmx_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .periph0(pad_periph[31:0]),
  .pull_up0(pad_pull_up[31:0]), .pull_dn0(pad_pull_dn[31:0]), .err(err_q)
);

// File: tb/pinmux_ctrl_bench.sv
`timescale 1ns/1ps
module pinmux_ctrl_bench;
  localparam int NB   = 2;
  localparam int NPAD = NB * 32;
  localparam int FW   = NPAD / 8;
  localparam logic [31:0] DRV_MASK = 32'h7373_7373; // even pads 2 bits, odd 3

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [NPAD-1:0]   pad_periph, pad_pull_up, pad_pull_dn;
  logic [NPAD*4-1:0] pad_func;
  logic [NPAD*3-1:0] pad_drive;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pinmux_ctrl #(.NB(NB)) u_pinmux_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_periph(pad_periph), .pad_func(pad_func), .pad_drive(pad_drive),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_sel[NB], m_pen[NB], m_pdir[NB], m_func[FW], m_drv[FW];
  logic [31:0] m_key, m_rdata;
  bit m_armed, m_err;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int r = int'(a[11:8]);
    int i = int'(a[7:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (r == 0 && i == 0) return m_key;
    if (r == 0 && i == 1) return {31'h0, m_err};
    if (r == 1 && i < NB) return m_sel[i];
    if (r == 2 && i < FW) return m_func[i];
    if (r == 3 && i < FW) return m_drv[i];
    if (r == 4 && i < NB) return m_pen[i];
    if (r == 5 && i < NB) return m_pdir[i];
    return 32'h0;
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] d);
    int r = int'(a[11:8]);
    int i = int'(a[7:2]);
    bit al = (a[1:0] == 2'b00);
    bit ok = m_armed && (m_key == ~d);
    bit grd = al && ((r == 1 && i < NB) || (r == 2 && i < FW) || (r == 3 && i < FW));
    if (al && r == 0 && i == 0) begin
      m_key = d; m_armed = 1;
    end else begin
      m_armed = 0;
      if (grd && !ok) m_err = 1;
      else if (grd) begin
        if (r == 1) m_sel[i] = d;
        if (r == 2) m_func[i] = d;
        if (r == 3) m_drv[i] = d & DRV_MASK;
      end
      if (al && r == 0 && i == 1 && d[0]) m_err = 0;
      if (al && r == 4 && i < NB) m_pen[i] = d;
      if (al && r == 5 && i < NB) m_pdir[i] = d;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin m_sel[i] = 0; m_pen[i] = 0; m_pdir[i] = 0; end
      for (int i = 0; i < FW; i++) begin m_func[i] = 0; m_drv[i] = 0; end
      m_key = 0; m_rdata = 0; m_armed = 0; m_err = 0;
    end else begin
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (bus_wr) m_write(bus_addr, bus_wdata);
    end
  end

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every pad output and the read port with the model each cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NPAD-1:0]   e_per, e_up, e_dn;
      logic [NPAD*4-1:0] e_fn;
      logic [NPAD*3-1:0] e_dr;
      for (int b = 0; b < NB; b++) begin
        e_per[b*32 +: 32] = m_sel[b];
        e_up[b*32 +: 32]  = m_pen[b] & m_pdir[b];
        e_dn[b*32 +: 32]  = m_pen[b] & ~m_pdir[b];
      end
      for (int p = 0; p < NPAD; p++) begin
        e_fn[p*4 +: 4] = m_func[p/8][(p%8)*4 +: 4];
        e_dr[p*3 +: 3] = m_drv[p/8][(p%8)*4 +: 3];
      end
      check("R2 pad_periph", 256'(pad_periph), 256'(e_per));
      check("R3 pad_func", 256'(pad_func), 256'(e_fn));
      check("R4 pad_drive", 256'(pad_drive), 256'(e_dr));
      check("R8 pull_up", 256'(pad_pull_up), 256'(e_up));
      check("R8 pull_dn", 256'(pad_pull_dn), 256'(e_dn));
      check("R9 rdata", 256'(bus_rdata), 256'(m_rdata));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 periph after reset", 256'(pad_periph), 256'(0));
    rd(12'h100, q); check("R1 sel word", 256'(q), 256'(0));
    rd(12'h004, q); check("R1 status", 256'(q), 256'(0));
    rd(12'h000, q); check("R1 key", 256'(q), 256'(0));

    // guarded write without key
    wr(12'h100, 32'h5);
    rd(12'h100, q); check("R7 unchanged", 256'(q), 256'(0));
    rd(12'h004, q); check("R7 err set", 256'(q), 256'(1));
    wr(12'h004, 32'h0);
    rd(12'h004, q); check("R7 write0 keeps", 256'(q), 256'(1));
    wr(12'h004, 32'h1);
    rd(12'h004, q); check("R7 w1c", 256'(q), 256'(0));

    // paired write
    wr(12'h000, ~32'h5); wr(12'h100, 32'h5);
    rd(12'h100, q); check("R5 accepted", 256'(q), 256'(5));
    check("R2 pad2 periph", 256'(pad_periph[2]), 256'(1));
    check("R2 pad1 gpio", 256'(pad_periph[1]), 256'(0));

    // one key, two guarded writes
    wr(12'h000, ~32'h3); wr(12'h104, 32'h3); wr(12'h104, 32'hF);
    rd(12'h104, q); check("R6 second dropped", 256'(q), 256'(3));
    check("R2 pad33 periph", 256'(pad_periph[33]), 256'(1));
    rd(12'h004, q); check("R6 err", 256'(q), 256'(1));
    wr(12'h004, 32'h1);

    // wrong complement
    wr(12'h000, 32'h1234_5678); wr(12'h200, 32'h1);
    rd(12'h200, q); check("R5 bad key", 256'(q), 256'(0));

    // read between key and write, key readback
    wr(12'h000, ~32'hA0);
    rd(12'h000, q); check("R9 key readback", 256'(q), 256'(32'hFFFF_FF5F));
    wr(12'h200, 32'hA0);
    check("R3 pad1 func", 256'(pad_func[7:4]), 256'(4'hA));
    rd(12'h200, q); check("R5 read between", 256'(q), 256'(32'hA0));

    // plain write consumes key
    wr(12'h000, ~32'h7); wr(12'h400, 32'h1); wr(12'h204, 32'h7);
    rd(12'h204, q); check("R6 plain consumes", 256'(q), 256'(0));

    // last key wins
    wr(12'h000, 32'h0); wr(12'h000, ~32'h30); wr(12'h204, 32'h30);
    rd(12'h204, q); check("R10 last key", 256'(q), 256'(32'h30));
    check("R3 pad9 func", 256'(pad_func[39:36]), 256'(3));

    // drive layout
    wr(12'h000, 32'h0); wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, q); check("R4 mask", 256'(q), 256'(32'h7373_7373));
    check("R4 pad0 24mA", 256'(pad_drive[2:0]), 256'(3));
    check("R4 pad1 24mA", 256'(pad_drive[5:3]), 256'(7));
    wr(12'h000, ~32'h31); wr(12'h300, 32'h31);
    check("R4 pad0 12mA", 256'(pad_drive[2:0]), 256'(1));
    check("R4 pad1 12mA", 256'(pad_drive[5:3]), 256'(3));

    // pulls
    wr(12'h004, 32'h1);
    wr(12'h400, 32'h3); wr(12'h500, 32'h5);
    check("R8 pad0 up", 256'(pad_pull_up[0]), 256'(1));
    check("R8 pad1 dn", 256'(pad_pull_dn[1]), 256'(1));
    check("R8 pad2 off", 256'({pad_pull_up[2], pad_pull_dn[2]}), 256'(0));
    rd(12'h004, q); check("R8 no err", 256'(q), 256'(0));

    // unmapped / misaligned
    rd(12'h600, q); check("R9 unmapped", 256'(q), 256'(0));
    rd(12'h102, q); check("R9 misaligned", 256'(q), 256'(0));

    // random traffic, checked against the model every cycle
    for (int k = 0; k < 1500; k++) begin
      logic [11:0] a;
      logic [31:0] d = $urandom;
      int kind = $urandom % 8;
      int w = $urandom % 9;
      case (kind)
        0: a = 12'h100 | 12'((w % NB) * 4);
        1: a = 12'h200 | 12'(w * 4);
        2: a = 12'h300 | 12'(w * 4);
        3: a = 12'h400 | 12'((w % NB) * 4);
        4: a = 12'h500 | 12'((w % NB) * 4);
        5: a = 12'h004;
        6: a = 12'h000;
        default: a = 12'(($urandom % 6) << 8) | 12'(w * 4);
      endcase
      if ($urandom % 2 == 0) wr(12'h000, ($urandom % 4 == 0) ? d : ~d);
      if ($urandom % 3 == 0) rd(a, d ^ 32'h0); else wr(a, d);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule